// File: doc/BRIEF.md
# Strided Block Access Sequencer

This block schedules one vector repeat of eight 32-byte data blocks onto a banked local buffer. In that buffer each bank group can serve one 32-byte row per cycle. A repeat is described by a start address and a block stride counted in 32-byte rows. Block k of the repeat therefore lives at base + k x stride x 32. The sequencer issues the eight accesses over as few cycles as the bank-group mapping allows. In each cycle no bank group is touched more than once.

A request is made by pulsing the start input together with the base address, the stride and the access direction. From the next cycle the block presents a per-cycle issue mask over the eight blocks and the address of every block. It keeps busy high until every block has been issued. It then pulses done together with the number of cycles the repeat took. When the blocks spread over distinct groups, the repeat completes in one cycle. When several blocks share a group, the repeat stretches to the size of the most crowded group. Reads of one source operand and writes of the destination operand follow the same rule.

Top module: `stride_blk_sched`

## Requirements
- R1: With the default widths, block k (0 to 7) is at (base + k x stride x 32) modulo 2^18. This address is presented on blk_addr_o bits [18k+17:18k]. It stays unchanged from the cycle after an accepted start until the next accepted start.
- R2: The bank group of a block is bits [8:5] of its address. A cycle never issues two blocks whose bank group is the same.
- R3: In each busy cycle, every bank group that still has pending blocks issues its lowest-numbered pending block. Over a repeat, each of the eight blocks is issued exactly once.
- R4: The cycle count of a repeat equals the largest number of blocks that share one bank group. For base 0x1FE00, stride 16 takes 8 cycles, stride 8 takes 4 cycles and stride 1 takes 1 cycle.
- R5: A stride of zero places all eight blocks at the base address. The repeat then takes eight cycles, issuing block k alone in cycle k.
- R6: busy_o goes high in the cycle after an accepted start. It stays high exactly for the issue cycles of the repeat. issue_o is all zero whenever busy_o is low.
- R7: done_o is high for exactly one cycle, the cycle after the last issue cycle, and busy_o is low in that cycle. cycles_o carries the cycle count of the repeat while done_o is high and holds it until the next repeat ends.
- R8: A start while busy_o is high is ignored, including on the last issue cycle: the addresses, the schedule and the mode do not change. A start in the done cycle is accepted.
- R9: write_o shows the direction latched at the accepted start (1 for write, 0 for read). The schedule does not depend on the direction.
- R10: After reset, busy_o, done_o, issue_o, write_o and cycles_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a new repeat (taken only when not busy) |
| base_i | input | 18 | Byte address of block 0 |
| stride_i | input | 8 | Distance between blocks, in 32-byte rows |
| write_i | input | 1 | Access direction: 1 write, 0 read |
| busy_o | output | 1 | A repeat is being issued |
| done_o | output | 1 | One-cycle pulse after the last issue cycle |
| issue_o | output | 8 | Blocks issued in this cycle, bit k for block k |
| blk_addr_o | output | 144 | Address of each block, 18 bits per block, block 0 lowest |
| write_o | output | 1 | Latched access direction |
| cycles_o | output | 4 | Issue cycles of the last completed repeat |

## Verification
Two functions can coincide with the end of a repeat: a new start and the final issue with its done pulse. A start raised on the last issue cycle must be dropped. A start raised in the done cycle must be taken, so the next repeat begins with no idle cycle. The bench provokes the first case by poking start on the final busy cycle and then checks that busy stays low after done. It provokes the second case by launching the next repeat from the very cycle in which it sees done. A scoreboard built from a per-group rank model of the eight addresses judges both cases cycle by cycle.

// File: rtl/sbs_pkg.sv
// Package: shared types for the strided block access sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sbs_pkg;

    // Direction of the accesses of one repeat.
    typedef enum logic {
        MODE_READ  = 1'b0,
        MODE_WRITE = 1'b1
    } acc_mode_e;

    // Sequencer control state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/sbs_addr_gen.sv
// Module: sbs_addr_gen
// Computes the byte address and bank-group index of each block of a repeat.
// Block k lies k strides (each stride a count of rows) above the base.
// Assumes the address wraps modulo 2^ADDR_W and that a row is 2^ROW_LOG2 bytes.
module sbs_addr_gen #(
    parameter int ADDR_W   = 18,
    parameter int STRIDE_W = 8,
    parameter int NUM_BLK  = 8,
    parameter int ROW_LOG2 = 5,
    parameter int GRP_W    = 4
) (
    input  logic [ADDR_W-1:0]         base_i,
    input  logic [STRIDE_W-1:0]       stride_i,
    output logic [NUM_BLK*ADDR_W-1:0] addr_o,
    output logic [NUM_BLK*GRP_W-1:0]  grp_o
);
    localparam int STEP_W = STRIDE_W + ROW_LOG2;

    logic [STEP_W-1:0] step_raw;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] chain [NUM_BLK];

    // Byte distance between neighbouring blocks.
    assign step_raw = {stride_i, {ROW_LOG2{1'b0}}};
    assign step     = ADDR_W'(step_raw);

    // Address chain: each block sits one step above its predecessor.
    generate
        for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
            if (k == 0) begin : g_first
                assign chain[k] = base_i;
            end else begin : g_next
                assign chain[k] = chain[k-1] + step;
            end
            assign addr_o[k*ADDR_W +: ADDR_W] = chain[k];
            assign grp_o[k*GRP_W +: GRP_W]    = chain[k][ROW_LOG2 +: GRP_W];
        end
    endgenerate

endmodule

// File: rtl/sbs_pick.sv
// Module: sbs_pick
// Selects, per bank group, the lowest-numbered pending block for this cycle.
// A block is issued when it is pending and no lower pending block shares its group.
// Assumes group indices are stable for the whole repeat. clk and rst_n feed the
// embedded checks only.
module sbs_pick #(
    parameter int NUM_BLK = 8,
    parameter int GRP_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_BLK-1:0]       pending_i,
    input  logic [NUM_BLK*GRP_W-1:0] grp_i,
    output logic [NUM_BLK-1:0]       issue_o
);
    localparam int NUM_GRP = 1 << GRP_W;

    logic [NUM_BLK-1:0] blocked;

    // Mark blocks shadowed by a lower pending block of the same group.
    always_comb begin
        blocked = '0;
        for (int k = 0; k < NUM_BLK; k++) begin
            for (int j = 0; j < NUM_BLK; j++) begin
                if (j < k && pending_i[j] &&
                    grp_i[j*GRP_W +: GRP_W] == grp_i[k*GRP_W +: GRP_W]) begin
                    blocked[k] = 1'b1;
                end
            end
        end
    end

    // Issue every pending block that is first in its group.
    assign issue_o = pending_i & ~blocked;

    // R3: progress - any pending work issues something this cycle.
    assert_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_i != '0) |-> (issue_o != '0));

    // R2: per bank group, at most one block leaves in a cycle.
    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp_chk
            logic [NUM_BLK-1:0] in_grp;
            always_comb begin
                for (int k = 0; k < NUM_BLK; k++) begin
                    in_grp[k] = (grp_i[k*GRP_W +: GRP_W] == GRP_W'(g));
                end
            end
            assert_one_per_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(issue_o & in_grp));
        end
    endgenerate

endmodule

// File: rtl/sbs_ctrl.sv
// Module: sbs_ctrl
// Accepts a repeat request, holds its description, tracks the pending blocks,
// counts issue cycles and produces busy, done and the final cycle count.
// Assumes the issue mask from the picker is non-empty while blocks are pending.
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int STRIDE_W = 8,
    parameter int NUM_BLK  = 8,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic                write_i,
    input  logic [NUM_BLK-1:0]  issue_i,
    output logic [ADDR_W-1:0]   base_q,
    output logic [STRIDE_W-1:0] stride_q,
    output logic [NUM_BLK-1:0]  pending_q,
    output logic                busy_o,
    output logic                done_o,
    output logic                write_o,
    output logic [CNT_W-1:0]    cycles_o
);
    seq_state_e         state_q;
    acc_mode_e          mode_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_BLK-1:0] remain;
    logic               accept;

    // A request is taken only while idle.
    assign accept = start_i && (state_q == ST_IDLE);
    // Blocks still owed after this cycle's issue.
    assign remain = pending_q & ~issue_i;

    // Main sequencing register set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mode_q    <= MODE_READ;
            base_q    <= '0;
            stride_q  <= '0;
            pending_q <= '0;
            cnt_q     <= '0;
            cycles_o  <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept) begin
                state_q   <= ST_RUN;
                mode_q    <= acc_mode_e'(write_i);
                base_q    <= base_i;
                stride_q  <= stride_i;
                pending_q <= '1;
                cnt_q     <= '0;
            end else if (state_q == ST_RUN) begin
                pending_q <= remain;
                cnt_q     <= cnt_q + 1'b1;
                if (remain == '0) begin
                    state_q  <= ST_IDLE;
                    done_o   <= 1'b1;
                    cycles_o <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy_o  = (state_q == ST_RUN);
    assign write_o = (mode_q == MODE_WRITE);

    // R6: an accepted start raises busy on the next cycle.
    assert_busy_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R8: a start during a repeat leaves the request description untouched.
    assert_ignore_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> ($stable(base_q) && $stable(stride_q) && $stable(write_o)));

    // R7: done lasts one cycle and follows a busy cycle with busy now low.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R4: a finished repeat took between one and NUM_BLK cycles.
    assert_cycle_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cycles_o >= CNT_W'(1) && cycles_o <= CNT_W'(NUM_BLK)));

    // R3: once cleared, a block is not pending again within the repeat.
    assert_no_reissue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ((pending_q & ~$past(pending_q)) == '0));

endmodule

// File: rtl/stride_blk_sched.sv
// Module: stride_blk_sched (top)
// Schedules the eight blocks of one strided vector repeat so that each bank
// group serves at most one row per cycle. Ties go to the lowest block number.
// Assumes the consumer takes every issued access in the cycle it is shown.
module stride_blk_sched #(
    parameter int ADDR_W   = 18,
    parameter int STRIDE_W = 8,
    parameter int NUM_BLK  = 8,
    parameter int ROW_LOG2 = 5,
    parameter int GRP_W    = 4,
    localparam int CNT_W   = $clog2(NUM_BLK + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [ADDR_W-1:0]         base_i,
    input  logic [STRIDE_W-1:0]       stride_i,
    input  logic                      write_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [NUM_BLK-1:0]        issue_o,
    output logic [NUM_BLK*ADDR_W-1:0] blk_addr_o,
    output logic                      write_o,
    output logic [CNT_W-1:0]          cycles_o
);
    logic [ADDR_W-1:0]        base_q;
    logic [STRIDE_W-1:0]      stride_q;
    logic [NUM_BLK-1:0]       pending_q;
    logic [NUM_BLK*GRP_W-1:0] grp;

    // Request holding, pending tracking and completion.
    sbs_ctrl #(
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W),
        .NUM_BLK  (NUM_BLK),
        .CNT_W    (CNT_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .base_i    (base_i),
        .stride_i  (stride_i),
        .write_i   (write_i),
        .issue_i   (issue_o),
        .base_q    (base_q),
        .stride_q  (stride_q),
        .pending_q (pending_q),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .write_o   (write_o),
        .cycles_o  (cycles_o)
    );

    // Block addresses and bank groups from the held request.
    sbs_addr_gen #(
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W),
        .NUM_BLK  (NUM_BLK),
        .ROW_LOG2 (ROW_LOG2),
        .GRP_W    (GRP_W)
    ) addr_i (
        .base_i   (base_q),
        .stride_i (stride_q),
        .addr_o   (blk_addr_o),
        .grp_o    (grp)
    );

    // Per-group lowest-first selection.
    sbs_pick #(
        .NUM_BLK (NUM_BLK),
        .GRP_W   (GRP_W)
    ) pick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending_q),
        .grp_i     (grp),
        .issue_o   (issue_o)
    );

    // R6: nothing is issued while idle.
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (issue_o == '0));

    // R6: every busy cycle issues at least one block.
    assert_busy_issues_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (issue_o != '0));

    // R1: block addresses hold while a repeat runs.
    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(blk_addr_o));

endmodule

// File: tb/stride_blk_sched_tb_top.sv
// Bench: scoreboard. The driver task derives per-cycle expected issue masks
// from a per-group rank model and queues them; the monitor pops them each busy cycle.
module stride_blk_sched_tb_top;
    localparam int AW = 18;
    localparam int SW = 8;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [SW-1:0] stride_i = '0;
    logic          write_i = 1'b0;
    logic          busy_o, done_o, write_o;
    logic [NB-1:0] issue_o;
    logic [NB*AW-1:0] blk_addr_o;
    logic [3:0]    cycles_o;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    bit done_prev = 1'b0;
    logic [NB-1:0] exp_q [$];
    logic [AW-1:0] exp_addr [NB];

    always #10 clk = ~clk;  // 50 MHz

    stride_blk_sched dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .base_i     (base_i),
        .stride_i   (stride_i),
        .write_i    (write_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .issue_o    (issue_o),
        .blk_addr_o (blk_addr_o),
        .write_o    (write_o),
        .cycles_o   (cycles_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Monitor: compare each busy cycle against the scoreboard.
    always @(negedge clk) begin
        if (mon_on) begin
            if (busy_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected busy cycle", 64'(issue_o), 64'h0);
                end else begin
                    logic [NB-1:0] e;
                    e = exp_q.pop_front();
                    check(issue_o == e, "R3", "issue mask", 64'(issue_o), 64'(e));
                end
            end else begin
                check(issue_o == '0, "R6", "issue while idle", 64'(issue_o), 64'h0);
            end
            check(!(done_o && done_prev), "R7", "done longer than one cycle",
                  64'(done_o), 64'h0);
            done_prev = done_o;
        end
    end

    // Build expected addresses and per-cycle masks; return the cycle count.
    task automatic model(input logic [AW-1:0] b, input logic [SW-1:0] s, output int ncyc);
        int rank [NB];
        ncyc = 0;
        for (int k = 0; k < NB; k++) begin
            exp_addr[k] = AW'(b + AW'(k) * AW'(s) * AW'(32));
        end
        for (int k = 0; k < NB; k++) begin
            rank[k] = 0;
            for (int j = 0; j < k; j++) begin
                if (exp_addr[j][8:5] == exp_addr[k][8:5]) rank[k]++;
            end
            if (rank[k] + 1 > ncyc) ncyc = rank[k] + 1;
        end
        for (int c = 0; c < ncyc; c++) begin
            logic [NB-1:0] m;
            m = '0;
            for (int k = 0; k < NB; k++) if (rank[k] == c) m[k] = 1'b1;
            exp_q.push_back(m);
        end
    endtask

    // Driver: queue expectations, pulse start, check the first busy cycle.
    task automatic launch(input logic [AW-1:0] b, input logic [SW-1:0] s,
                          input bit wr, output int ncyc);
        model(b, s, ncyc);
        base_i = b; stride_i = s; write_i = wr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R6", "busy after start", 64'(busy_o), 64'h1);
        check(write_o == wr, "R9", "latched direction", 64'(write_o), 64'(wr));
        for (int k = 0; k < NB; k++) begin
            check(blk_addr_o[k*AW +: AW] == exp_addr[k], "R1", "block address",
                  64'(blk_addr_o[k*AW +: AW]), 64'(exp_addr[k]));
        end
    endtask

    // Wait for done and judge the count and the drained scoreboard.
    task automatic finish_check(input int ncyc, input string req);
        for (int i = 0; i < 20 && !done_o; i++) @(negedge clk);
        check(done_o == 1'b1, "R7", "done seen", 64'(done_o), 64'h1);
        check(busy_o == 1'b0, "R7", "busy low with done", 64'(busy_o), 64'h0);
        check(cycles_o == 4'(ncyc), req, "cycle count", 64'(cycles_o), 64'(ncyc));
        check(exp_q.size() == 0, "R3", "all blocks issued", 64'(exp_q.size()), 64'h0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", 64'h0, 64'h1);
        summary();
    end

    initial begin
        int n;
        logic [AW-1:0] bases [4];
        logic [SW-1:0] strides [13];
        bases = '{18'h1FE00, 18'h00000, 18'h3FFE0, 18'h12340};
        strides = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd7, 8'd8,
                    8'd16, 8'd32, 8'd64, 8'd128, 8'd255};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state.
        check(busy_o == 1'b0 && done_o == 1'b0, "R10", "busy/done after reset",
              64'({busy_o, done_o}), 64'h0);
        check(issue_o == '0 && write_o == 1'b0 && cycles_o == '0, "R10",
              "outputs after reset", 64'({issue_o, write_o, cycles_o}), 64'h0);
        mon_on = 1'b1;

        // R4: the stated examples.
        launch(18'h1FE00, 8'd16, 1'b0, n);
        check(n == 8, "R4", "model stride 16", 64'(n), 64'd8);
        finish_check(8, "R4");
        launch(18'h1FE00, 8'd8, 1'b1, n);
        check(n == 4, "R4", "model stride 8", 64'(n), 64'd4);
        finish_check(4, "R4");
        launch(18'h1FE00, 8'd1, 1'b0, n);
        finish_check(1, "R4");

        // R5: zero stride serialises all eight blocks.
        launch(18'h00A40, 8'd0, 1'b1, n);
        finish_check(8, "R5");

        // R2/R3/R9: sweep of bases, strides and directions.
        for (int bi = 0; bi < 4; bi++) begin
            for (int si = 0; si < 13; si++) begin
                launch(bases[bi], strides[si], 1'((bi + si) & 1), n);
                finish_check(n, "R2");
            end
        end

        // R8: start in the middle of a repeat is ignored.
        launch(18'h1FE00, 8'd16, 1'b0, n);
        @(negedge clk); @(negedge clk);
        base_i = 18'h00020; stride_i = 8'd1; write_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(blk_addr_o[AW +: AW] == exp_addr[1], "R8", "address after ignored start",
              64'(blk_addr_o[AW +: AW]), 64'(exp_addr[1]));
        check(write_o == 1'b0, "R8", "mode after ignored start", 64'(write_o), 64'h0);
        finish_check(8, "R8");

        // R8: start on the last issue cycle is ignored too.
        launch(18'h1FE00, 8'd8, 1'b0, n);
        @(negedge clk); @(negedge clk); @(negedge clk);
        base_i = 18'h00100; stride_i = 8'd2; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        finish_check(4, "R8");
        @(negedge clk);
        check(busy_o == 1'b0, "R8", "no repeat from last-cycle start", 64'(busy_o), 64'h0);
        check(cycles_o == 4'd4, "R7", "count held after done", 64'(cycles_o), 64'd4);

        // R8: start in the done cycle is accepted back to back.
        launch(18'h00000, 8'd4, 1'b1, n);
        finish_check(2, "R8");
        launch(18'h1FE00, 8'd16, 1'b0, n);
        finish_check(8, "R8");

        @(negedge clk);
        summary();
    end

endmodule